// File: doc/BRIEF.md
# Partition Freeze Filter

The filter holds a freeze record for every partition number, up to 256 of them. Each record has two bits: one for the memory-mapped side and one for the DMA side. Every transaction that crosses the block carries a partition number and a kind. The filter looks up that partition's record and returns a verdict for the transaction:

- pass it through;
- drop it;
- complete it with read data of all ones.

A one-hot cause field says which freeze bit produced the verdict.

An error-report strobe freezes a partition on both sides at once. Software can freeze a partition with a set command. It can unfreeze the two sides separately with two clear commands, and it can read a record back. Transactions enter on a valid/ready port. Verdicts leave on a one-stage valid/ready port that holds its contents while the consumer stalls. The error and software ports are plain strobes and are never back-pressured.

Top module: `pfz_filter`

Encodings used on the ports:

- `txn_kind`: 0 MMIO read, 1 MMIO write, 2 DMA read, 3 DMA write, 4 interrupt message. Codes 5 to 7 are reserved and always pass.
- `vrd_verdict`: 0 pass, 1 drop, 2 all-ones.
- `sw_cmd`: 0 read, 1 set, 2 clear MMIO bit, 3 clear DMA bit.
- Record and cause layout: bit 0 is the MMIO freeze, bit 1 is the DMA freeze.

## Requirements
- R1: After reset every record reads 2'b00, `vrd_valid` is 0 and `txn_ready` is 1.
- R2: An `err_valid` strobe sets both bits of the addressed record at the clock edge where it is sampled.
- R3: The clear-MMIO command (`sw_cmd`=2) zeroes bit 0 of the addressed record and leaves bit 1 unchanged.
- R4: The clear-DMA command (`sw_cmd`=3) zeroes bit 1 of the addressed record and leaves bit 0 unchanged.
- R5: When an error report and a clear command address the same record in one cycle, both bits end up set.
- R6: An MMIO write (kind 1) to a record whose bit 0 is set gets verdict 1 (drop) and cause 2'b01.
- R7: An MMIO read (kind 0) to a record whose bit 0 is set gets verdict 2, cause 2'b01 and `vrd_rdata` all ones.
- R8: A DMA read (kind 2) to a record whose bit 1 is set gets verdict 2 and cause 2'b10. A DMA write (kind 3) to such a record gets verdict 1 and cause 2'b10.
- R9: An interrupt message (kind 4) to a record whose bit 1 is set gets verdict 1 and cause 2'b10.
- R10: A transaction whose governing bit is clear gets verdict 0, cause 2'b00 and `vrd_rdata` zero.
- R11: A transaction accepted at an edge (`txn_valid` and `txn_ready` both high) appears on the verdict port after that edge. `txn_ready` equals `!vrd_valid || vrd_ready`. While `vrd_valid` is high and `vrd_ready` is low, every verdict output holds.
- R12: A software set command (`sw_cmd`=1) sets both bits of the addressed record.
- R13: A read command (`sw_cmd`=0) raises `sw_rd_valid` for one cycle after its edge. `sw_rd_bits` then shows the addressed record as it was before that edge.
- R14: A verdict uses the record as it stood before the acceptance edge, so a freeze sampled at that same edge affects only later transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | Error report strobe |
| err_ep | input | EP_W | Partition named by the error report |
| sw_valid | input | 1 | Software command strobe |
| sw_cmd | input | 2 | Software command code |
| sw_ep | input | EP_W | Partition named by the command |
| sw_rd_valid | output | 1 | Read-back data valid |
| sw_rd_bits | output | 2 | Read-back record {dma, mmio} |
| txn_valid | input | 1 | Transaction offered |
| txn_ready | output | 1 | Transaction accepted when high with valid |
| txn_ep | input | EP_W | Transaction partition number |
| txn_kind | input | 3 | Transaction kind code |
| vrd_valid | output | 1 | Verdict valid |
| vrd_ready | input | 1 | Verdict consumer ready |
| vrd_ep | output | EP_W | Partition of the verdict's transaction |
| vrd_kind | output | 3 | Kind of the verdict's transaction |
| vrd_verdict | output | 2 | Verdict code |
| vrd_cause | output | 2 | Freeze bit that caused the verdict |
| vrd_rdata | output | DATA_W | Substitute read data |

## Verification
The properties assume a few things about the inputs:

- partition numbers below the table depth;
- `sw_cmd` holds only one of the four defined codes while `sw_valid` is high;
- a stalled transaction keeps its fields until it is accepted.

They put no limit on when `vrd_ready` drops. The stimulus honours these assumptions: it drives only defined kinds and commands on valid partitions, and it holds the second transaction steady during the stall test. Error reports are issued both alone and in the same cycle as clear commands and as transactions, which exercises the precedence cases.

// File: rtl/pfz_pkg.sv
package pfz_pkg;
  typedef enum logic [2:0] {
    K_MMIO_RD = 3'd0,
    K_MMIO_WR = 3'd1,
    K_DMA_RD  = 3'd2,
    K_DMA_WR  = 3'd3,
    K_MSI     = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    V_PASS = 2'd0,
    V_DROP = 2'd1,
    V_ONES = 2'd2
  } verdict_e;

  typedef enum logic [1:0] {
    C_READ     = 2'd0,
    C_SET      = 2'd1,
    C_CLR_MMIO = 2'd2,
    C_CLR_DMA  = 2'd3
  } swcmd_e;

  localparam int B_MMIO = 0;
  localparam int B_DMA  = 1;
endpackage

// File: rtl/pfz_table.sv
module pfz_table
  import pfz_pkg::*;
#(
  parameter int NUM_EP = 256,
  parameter int EP_W   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            err_valid,
  input  logic [EP_W-1:0] err_ep,
  input  logic            sw_valid,
  input  logic [1:0]      sw_cmd,
  input  logic [EP_W-1:0] sw_ep,
  input  logic [EP_W-1:0] lk_ep,
  output logic [1:0]      lk_bits,
  output logic            sw_rd_valid,
  output logic [1:0]      sw_rd_bits
);
  logic [NUM_EP-1:0] mmio_q, dma_q;
  logic [NUM_EP-1:0] frz_hit, clrm_hit, clrd_hit;

  logic sw_set, sw_clrm, sw_clrd, sw_rd;
  assign sw_set  = sw_valid && (sw_cmd == C_SET);
  assign sw_clrm = sw_valid && (sw_cmd == C_CLR_MMIO);
  assign sw_clrd = sw_valid && (sw_cmd == C_CLR_DMA);
  assign sw_rd   = sw_valid && (sw_cmd == C_READ);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_dec
    logic err_here, sw_here;
    assign err_here    = err_valid && (err_ep == EP_W'(i));
    assign sw_here     = sw_ep == EP_W'(i);
    assign frz_hit[i]  = err_here || (sw_set && sw_here);
    assign clrm_hit[i] = sw_clrm && sw_here;
    assign clrd_hit[i] = sw_clrd && sw_here;
  end

  // freeze dominates a clear aimed at the same record
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mmio_q <= '0;
      dma_q  <= '0;
    end else begin
      mmio_q <= frz_hit | (mmio_q & ~clrm_hit);
      dma_q  <= frz_hit | (dma_q & ~clrd_hit);
    end
  end

  function automatic logic [1:0] rec(input logic [EP_W-1:0] ep);
    logic [1:0] r;
    r = 2'b00;
    if (32'(ep) < NUM_EP) begin
      r[B_MMIO] = mmio_q[ep];
      r[B_DMA]  = dma_q[ep];
    end
    return r;
  endfunction

  assign lk_bits = rec(lk_ep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_rd_valid <= 1'b0;
      sw_rd_bits  <= 2'b00;
    end else begin
      sw_rd_valid <= sw_rd;
      sw_rd_bits  <= sw_rd ? rec(sw_ep) : 2'b00;
    end
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mmio_q == '0) && (dma_q == '0));

  a_r2_err_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> mmio_q[$past(err_ep)] && dma_q[$past(err_ep)]);

  a_r5_freeze_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && (sw_clrm || sw_clrd) && (err_ep == sw_ep))
      |=> mmio_q[$past(sw_ep)] && dma_q[$past(sw_ep)]);

  a_r3_clr_mmio_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clrm && !(err_valid && (err_ep == sw_ep)))
      |=> !mmio_q[$past(sw_ep)] && (dma_q[$past(sw_ep)] == $past(dma_q[sw_ep])));

  a_r4_clr_dma_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clrd && !(err_valid && (err_ep == sw_ep)))
      |=> !dma_q[$past(sw_ep)] && (mmio_q[$past(sw_ep)] == $past(mmio_q[sw_ep])));

  a_r13_read_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rd_valid |-> $past(sw_valid) && ($past(sw_cmd) == C_READ));
endmodule

// File: rtl/pfz_judge.sv
module pfz_judge
  import pfz_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [1:0]        frz,
  input  logic [2:0]        kind,
  output logic [1:0]        verdict,
  output logic [1:0]        cause,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    verdict = V_PASS;
    cause   = 2'b00;
    case (kind_e'(kind))
      K_MMIO_RD: if (frz[B_MMIO]) begin verdict = V_ONES; cause = 2'b01; end
      K_MMIO_WR: if (frz[B_MMIO]) begin verdict = V_DROP; cause = 2'b01; end
      K_DMA_RD:  if (frz[B_DMA])  begin verdict = V_ONES; cause = 2'b10; end
      K_DMA_WR:  if (frz[B_DMA])  begin verdict = V_DROP; cause = 2'b10; end
      K_MSI:     if (frz[B_DMA])  begin verdict = V_DROP; cause = 2'b10; end
      default: ;
    endcase
    rdata = (verdict == V_ONES) ? '1 : '0;
  end
endmodule

// File: rtl/pfz_outreg.sv
module pfz_outreg #(
  parameter int EP_W   = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [EP_W-1:0]   in_ep,
  input  logic [2:0]        in_kind,
  input  logic [1:0]        in_verdict,
  input  logic [1:0]        in_cause,
  input  logic [DATA_W-1:0] in_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [EP_W-1:0]   out_ep,
  output logic [2:0]        out_kind,
  output logic [1:0]        out_verdict,
  output logic [1:0]        out_cause,
  output logic [DATA_W-1:0] out_rdata
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_ep      <= '0;
      out_kind    <= '0;
      out_verdict <= '0;
      out_cause   <= '0;
      out_rdata   <= '0;
    end else if (in_valid && in_ready) begin
      out_valid   <= 1'b1;
      out_ep      <= in_ep;
      out_kind    <= in_kind;
      out_verdict <= in_verdict;
      out_cause   <= in_cause;
      out_rdata   <= in_rdata;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r11_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid &&
      $stable({out_ep, out_kind, out_verdict, out_cause, out_rdata}));

  a_r11_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/pfz_filter.sv
module pfz_filter
  import pfz_pkg::*;
#(
  parameter  int NUM_EP = 256,
  parameter  int DATA_W = 64,
  localparam int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  input  logic [EP_W-1:0]   err_ep,
  input  logic              sw_valid,
  input  logic [1:0]        sw_cmd,
  input  logic [EP_W-1:0]   sw_ep,
  output logic              sw_rd_valid,
  output logic [1:0]        sw_rd_bits,
  input  logic              txn_valid,
  output logic              txn_ready,
  input  logic [EP_W-1:0]   txn_ep,
  input  logic [2:0]        txn_kind,
  output logic              vrd_valid,
  input  logic              vrd_ready,
  output logic [EP_W-1:0]   vrd_ep,
  output logic [2:0]        vrd_kind,
  output logic [1:0]        vrd_verdict,
  output logic [1:0]        vrd_cause,
  output logic [DATA_W-1:0] vrd_rdata
);
  logic [1:0]        lk_bits;
  logic [1:0]        j_verdict, j_cause;
  logic [DATA_W-1:0] j_rdata;

  pfz_table #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .err_valid(err_valid), .err_ep(err_ep),
    .sw_valid(sw_valid), .sw_cmd(sw_cmd), .sw_ep(sw_ep),
    .lk_ep(txn_ep), .lk_bits(lk_bits),
    .sw_rd_valid(sw_rd_valid), .sw_rd_bits(sw_rd_bits)
  );

  pfz_judge #(.DATA_W(DATA_W)) u_judge (
    .frz(lk_bits), .kind(txn_kind),
    .verdict(j_verdict), .cause(j_cause), .rdata(j_rdata)
  );

  pfz_outreg #(.EP_W(EP_W), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(txn_valid), .in_ready(txn_ready),
    .in_ep(txn_ep), .in_kind(txn_kind), .in_verdict(j_verdict),
    .in_cause(j_cause), .in_rdata(j_rdata),
    .out_valid(vrd_valid), .out_ready(vrd_ready),
    .out_ep(vrd_ep), .out_kind(vrd_kind), .out_verdict(vrd_verdict),
    .out_cause(vrd_cause), .out_rdata(vrd_rdata)
  );

  a_r10_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd_valid && (vrd_verdict == V_PASS)) |-> (vrd_cause == 2'b00) && (vrd_rdata == '0));

  a_r7_ones_data: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd_valid && (vrd_verdict == V_ONES)) |-> (&vrd_rdata) && $onehot(vrd_cause));

  a_r6_cause_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd_valid && (vrd_cause != 2'b00)) |-> (vrd_verdict != V_PASS) && $onehot0(vrd_cause));
endmodule

// File: tb/pfz_filter_bench.sv
module pfz_filter_bench;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic err_valid = 0, sw_valid = 0, txn_valid = 0, vrd_ready = 1;
  logic [7:0] err_ep = 0, sw_ep = 0, txn_ep = 0;
  logic [1:0] sw_cmd = 0;
  logic [2:0] txn_kind = 0;
  logic sw_rd_valid, txn_ready, vrd_valid;
  logic [1:0] sw_rd_bits, vrd_verdict, vrd_cause;
  logic [7:0] vrd_ep;
  logic [2:0] vrd_kind;
  logic [DW-1:0] vrd_rdata;

  pfz_filter #(.NUM_EP(256), .DATA_W(DW)) u_pfz_filter (
    .clk(clk), .rst_n(rst_n),
    .err_valid(err_valid), .err_ep(err_ep),
    .sw_valid(sw_valid), .sw_cmd(sw_cmd), .sw_ep(sw_ep),
    .sw_rd_valid(sw_rd_valid), .sw_rd_bits(sw_rd_bits),
    .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_ep(txn_ep), .txn_kind(txn_kind),
    .vrd_valid(vrd_valid), .vrd_ready(vrd_ready),
    .vrd_ep(vrd_ep), .vrd_kind(vrd_kind), .vrd_verdict(vrd_verdict),
    .vrd_cause(vrd_cause), .vrd_rdata(vrd_rdata)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct packed {
    logic [1:0] act;   // 0 txn, 1 error report, 2 software command
    logic [1:0] cmd;
    logic [7:0] ep;
    logic [2:0] kind;
    logic [1:0] verd;
    logic [1:0] cause;
    logic [4:0] rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd0, 8'd3,   3'd0, 2'd0, 2'b00, 5'd10}, // R10 unfrozen read
    '{2'd1, 2'd0, 8'd3,   3'd0, 2'd0, 2'b00, 5'd2},  // R2 error on 3
    '{2'd0, 2'd0, 8'd3,   3'd0, 2'd2, 2'b01, 5'd7},  // R7
    '{2'd0, 2'd0, 8'd3,   3'd1, 2'd1, 2'b01, 5'd6},  // R6
    '{2'd0, 2'd0, 8'd3,   3'd2, 2'd2, 2'b10, 5'd8},  // R8 dma read
    '{2'd0, 2'd0, 8'd3,   3'd3, 2'd1, 2'b10, 5'd8},  // R8 dma write
    '{2'd0, 2'd0, 8'd3,   3'd4, 2'd1, 2'b10, 5'd9},  // R9
    '{2'd0, 2'd0, 8'd4,   3'd1, 2'd0, 2'b00, 5'd10}, // R10 neighbour
    '{2'd2, 2'd2, 8'd3,   3'd0, 2'd0, 2'b00, 5'd3},
    '{2'd0, 2'd0, 8'd3,   3'd1, 2'd0, 2'b00, 5'd3},  // R3 mmio cleared
    '{2'd0, 2'd0, 8'd3,   3'd4, 2'd1, 2'b10, 5'd3},  // R3 dma kept
    '{2'd2, 2'd3, 8'd3,   3'd0, 2'd0, 2'b00, 5'd4},
    '{2'd0, 2'd0, 8'd3,   3'd3, 2'd0, 2'b00, 5'd4},  // R4
    '{2'd2, 2'd1, 8'd255, 3'd0, 2'd0, 2'b00, 5'd12},
    '{2'd0, 2'd0, 8'd255, 3'd0, 2'd2, 2'b01, 5'd12}, // R12
    '{2'd0, 2'd0, 8'd255, 3'd2, 2'd2, 2'b10, 5'd12},
    '{2'd2, 2'd3, 8'd255, 3'd0, 2'd0, 2'b00, 5'd4},
    '{2'd0, 2'd0, 8'd255, 3'd4, 2'd0, 2'b00, 5'd4},
    '{2'd0, 2'd0, 8'd255, 3'd1, 2'd1, 2'b01, 5'd4},  // mmio kept
    '{2'd2, 2'd2, 8'd0,   3'd0, 2'd0, 2'b00, 5'd3},
    '{2'd0, 2'd0, 8'd0,   3'd0, 2'd0, 2'b00, 5'd10}
  };

  task automatic check(input int rq, input string what,
                       input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %h expected %h", rq, what, got, exp);
    end
  endtask

  task automatic run_txn(input logic [7:0] ep, input logic [2:0] k,
                         input logic [1:0] ev, input logic [1:0] ec, input int rq);
    @(negedge clk);
    txn_valid = 1; txn_ep = ep; txn_kind = k; vrd_ready = 1;
    @(negedge clk);
    txn_valid = 0;
    check(11, "verdict valid", DW'(vrd_valid), DW'(1));
    check(rq, "verdict", DW'(vrd_verdict), DW'(ev));
    check(rq, "cause", DW'(vrd_cause), DW'(ec));
    check(rq == 7 ? 7 : rq, "rdata", vrd_rdata, (ev == 2'd2) ? '1 : '0);
  endtask

  task automatic pulse_err(input logic [7:0] ep);
    @(negedge clk);
    err_valid = 1; err_ep = ep;
    @(negedge clk);
    err_valid = 0;
  endtask

  task automatic sw_op(input logic [1:0] c, input logic [7:0] ep);
    @(negedge clk);
    sw_valid = 1; sw_cmd = c; sw_ep = ep;
    @(negedge clk);
    sw_valid = 0;
  endtask

  task automatic sw_read(input logic [7:0] ep, input logic [1:0] exp, input int rq);
    sw_op(2'd0, ep);
    check(13, "read valid", DW'(sw_rd_valid), DW'(1));
    check(rq, "record", DW'(sw_rd_bits), DW'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(1, "vrd_valid", DW'(vrd_valid), DW'(0));
    check(1, "txn_ready", DW'(txn_ready), DW'(1));
    check(1, "rd_valid", DW'(sw_rd_valid), DW'(0));
    sw_read(8'd0, 2'b00, 1);
    sw_read(8'd255, 2'b00, 1);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].act)
        2'd0: run_txn(VEC[i].ep, VEC[i].kind, VEC[i].verd, VEC[i].cause, int'(VEC[i].rq));
        2'd1: pulse_err(VEC[i].ep);
        default: sw_op(VEC[i].cmd, VEC[i].ep);
      endcase
    end

    // R13 partial record read back
    sw_read(8'd255, 2'b01, 13);
    // R2 both bits set by a report
    pulse_err(8'd17);
    sw_read(8'd17, 2'b11, 2);

    // R5 report and clear-MMIO on one record in one cycle
    @(negedge clk);
    err_valid = 1; err_ep = 8'd40; sw_valid = 1; sw_cmd = 2'd2; sw_ep = 8'd40;
    @(negedge clk);
    err_valid = 0; sw_valid = 0;
    sw_read(8'd40, 2'b11, 5);
    // R5 with clear-DMA
    @(negedge clk);
    err_valid = 1; err_ep = 8'd40; sw_valid = 1; sw_cmd = 2'd3; sw_ep = 8'd40;
    @(negedge clk);
    err_valid = 0; sw_valid = 0;
    sw_read(8'd40, 2'b11, 5);

    // R14 freeze in the acceptance cycle does not affect that transaction
    @(negedge clk);
    err_valid = 1; err_ep = 8'd60;
    txn_valid = 1; txn_ep = 8'd60; txn_kind = 3'd1; vrd_ready = 1;
    @(negedge clk);
    err_valid = 0; txn_valid = 0;
    check(14, "same-cycle verdict", DW'(vrd_verdict), DW'(0));
    run_txn(8'd60, 3'd1, 2'd1, 2'b01, 14);

    // R11 back-pressure
    @(negedge clk);
    vrd_ready = 0;
    txn_valid = 1; txn_ep = 8'd60; txn_kind = 3'd0;
    @(negedge clk);
    txn_ep = 8'd3; txn_kind = 3'd1;
    check(11, "ready low in stall", DW'(txn_ready), DW'(0));
    repeat (3) @(negedge clk);
    check(11, "held valid", DW'(vrd_valid), DW'(1));
    check(11, "held verdict", DW'(vrd_verdict), DW'(2));
    check(11, "held ep", DW'(vrd_ep), DW'(60));
    vrd_ready = 1;
    @(negedge clk);
    txn_valid = 0;
    check(11, "next verdict", DW'(vrd_verdict), DW'(0));
    check(11, "next ep", DW'(vrd_ep), DW'(3));
    @(negedge clk);
    check(11, "drained", DW'(vrd_valid), DW'(0));

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule